// File: doc/BRIEF.md
# Critical Interrupt Entry Unit

This block decides when a critical interrupt is taken and produces every register value the core needs on entry. The request line is active low and level sensitive: the requester holds it asserted until it sees the take pulse. Each clock the unit samples the request together with the critical-enable bit of the incoming state word. When both allow it, the unit commits one coordinated update on a single edge. The return address and the old state word go into the two save registers. A new state word with the interrupt-sensitive bits cleared is produced. The handler vector is formed, and a one-cycle take pulse is raised.

The handler vector is built from three parts, most significant first: the upper half of the vector prefix register, a 12-bit offset, and four zero bits. The offset comes from the stored offset register when the requester autovectors. When the requester supplies its own offset, that offset is used instead. The debug-enable bit of the new state word is cleared according to two configuration bits. After a take, the unit ignores the still-held request until the critical-enable bit has been seen low and then high again. This stops the handler from being re-entered before it has released the line.

Top module: `critEntry`

## Requirements
- R1: While reset (rstN low) is applied and after it is released, takeOut, retSave, stateSave, stateNew and vecOut are all zero until the first take.
- R2: A take happens only for a clock edge at which reqN is 0 and state bit 17 (critical enable) of stateIn is 1, with the unit armed. takeOut is high during the cycle after that edge.
- R3: On a take, vecOut equals {vecPrefix, selected 12-bit offset, 4'b0000}: prefix in bits 31:16, offset in bits 15:4, and bits 3:0 zero.
- R4: The selected offset is extOff when autoVecN is 1 (autovector negated) at the sampling edge. It is vecOffReg when autoVecN is 0.
- R5: On a take, retSave holds the nextPc value and stateSave holds the full stateIn value, both from the sampling edge.
- R6: On a take, stateNew equals stateIn with bits 26, 25, 18, 17, 15, 14, 13, 11, 8, 5, 4 and 1 cleared. All other bits, including bit 12 (machine-check enable), are copied unchanged apart from R7.
- R7: Bit 9 (debug enable) of stateNew is cleared when dbgCfg[0] (debug unit enabled) is 0 or dbgCfg[1] (critical entry clears debug) is 1. Otherwise bit 9 is copied from stateIn.
- R8: retSave, stateSave, stateNew and vecOut change only on the edge that raises takeOut. In any other cycle they hold their values.
- R9: takeOut lasts exactly one cycle. After a take, a request that stays asserted with critical enable high is not taken again until critical enable has been sampled 0 at some edge and then 1 again.
- R10: A request that arrives while critical enable is 0 stays pending. It is taken at the first edge at which critical enable is 1 and the request is still asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqN | input | 1 | Critical interrupt request, active low, level sensitive |
| autoVecN | input | 1 | Autovector strobe, active low; high selects extOff |
| extOff | input | 12 | Offset supplied by the requester |
| nextPc | input | 32 | Address of the instruction that would execute next |
| stateIn | input | 32 | Current machine state word |
| vecPrefix | input | 16 | Upper half of the vector prefix register |
| vecOffReg | input | 12 | Offset field of the stored critical offset register |
| dbgCfg | input | 2 | Bit 0 debug unit enabled, bit 1 critical entry clears debug enable |
| retSave | output | 32 | Save register 0: return address |
| stateSave | output | 32 | Save register 1: state word at entry |
| stateNew | output | 32 | State word to load on entry |
| vecOut | output | 32 | Handler vector address |
| takeOut | output | 1 | One-cycle take pulse |

## Verification
The hardest situation to reach is the re-arm path. The request line is still held after a take while critical enable toggles, and the unit must stay quiet through the held cycles, stay quiet through the low phase, and fire exactly once when enable returns. A directed sequence keeps reqN low across several cycles, drops critical enable for one cycle, and raises it again. Around that sequence, a sweep crosses every combination of enable, request, autovector strobe and both debug configuration bits with several state-word and address patterns. Each case first arms the unit with a low-enable cycle, so every pending, taken and held case is reached from a known state.

// File: rtl/critEntryPkg.sv
package critEntryPkg;

  // state word bit positions (behaviour depends on them)
  localparam int ST_USER_LOCK  = 26;
  localparam int ST_VEC_UNIT   = 25;
  localparam int ST_WAIT       = 18;
  localparam int ST_CRIT_EN    = 17;
  localparam int ST_EXT_EN     = 15;
  localparam int ST_USER_MODE  = 14;
  localparam int ST_FLOAT      = 13;
  localparam int ST_MCHK_EN    = 12;
  localparam int ST_FP_MODE0   = 11;
  localparam int ST_DBG_EN     = 9;
  localparam int ST_FP_MODE1   = 8;
  localparam int ST_INST_SPACE = 5;
  localparam int ST_DATA_SPACE = 4;
  localparam int ST_RECOV      = 1;

  localparam int CLR_COUNT = 12;

  typedef struct packed {
    logic capture;    // commit all entry registers this edge
    logic useExtOff;  // take offset from requester
    logic clearDbg;   // clear debug-enable in new state
  } entryStrobe_t;

  function automatic int clrBitAt(input int idx);
    case (idx)
      0:  return ST_USER_LOCK;
      1:  return ST_VEC_UNIT;
      2:  return ST_WAIT;
      3:  return ST_CRIT_EN;
      4:  return ST_EXT_EN;
      5:  return ST_USER_MODE;
      6:  return ST_FLOAT;
      7:  return ST_FP_MODE0;
      8:  return ST_FP_MODE1;
      9:  return ST_INST_SPACE;
      10: return ST_DATA_SPACE;
      default: return ST_RECOV;
    endcase
  endfunction

endpackage

// File: rtl/critEntryCtl.sv
module critEntryCtl
  import critEntryPkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         reqN,
  input  logic         autoVecN,
  input  logic         critEn,
  input  logic         dbgUnitEn,
  input  logic         dbgClrCfg,
  output entryStrobe_t strobe,
  output logic         takeOut
);

  logic armed;

  always_comb begin
    strobe.capture   = !reqN && critEn && armed;
    strobe.useExtOff = autoVecN;
    strobe.clearDbg  = !dbgUnitEn || dbgClrCfg;
  end

  // disarm on take, rearm once critical enable is seen low
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armed   <= 1'b1;
      takeOut <= 1'b0;
    end else begin
      takeOut <= strobe.capture;
      if (strobe.capture)
        armed <= 1'b0;
      else if (!critEn)
        armed <= 1'b1;
    end
  end

endmodule

// File: rtl/critEntryDp.sv
module critEntryDp
  import critEntryPkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int STATE_W = 32,
  parameter int OFF_W   = 12,
  parameter int ALIGN_W = 4,
  localparam int PFX_W  = ADDR_W - OFF_W - ALIGN_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  entryStrobe_t       strobe,
  input  logic [OFF_W-1:0]   extOff,
  input  logic [ADDR_W-1:0]  nextPc,
  input  logic [STATE_W-1:0] stateIn,
  input  logic [PFX_W-1:0]   vecPrefix,
  input  logic [OFF_W-1:0]   vecOffReg,
  output logic [ADDR_W-1:0]  retSave,
  output logic [STATE_W-1:0] stateSave,
  output logic [STATE_W-1:0] stateNew,
  output logic [ADDR_W-1:0]  vecOut
);

  logic [STATE_W-1:0] clrMask;
  logic [STATE_W-1:0] stateNext;
  logic [OFF_W-1:0]   offSel;
  logic [ADDR_W-1:0]  vecNext;

  // build the fixed clear mask, one generated term per bit
  for (genvar b = 0; b < STATE_W; b++) begin : g_mask
    always_comb begin
      clrMask[b] = 1'b0;
      for (int k = 0; k < CLR_COUNT; k++)
        if (clrBitAt(k) == b) clrMask[b] = 1'b1;
    end
  end

  always_comb begin
    stateNext = stateIn & ~clrMask;
    if (strobe.clearDbg) stateNext[ST_DBG_EN] = 1'b0;
    offSel  = strobe.useExtOff ? extOff : vecOffReg;
    vecNext = {vecPrefix, offSel, {ALIGN_W{1'b0}}};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      retSave   <= '0;
      stateSave <= '0;
      stateNew  <= '0;
      vecOut    <= '0;
    end else if (strobe.capture) begin
      retSave   <= nextPc;
      stateSave <= stateIn;
      stateNew  <= stateNext;
      vecOut    <= vecNext;
    end
  end

endmodule

// File: rtl/critEntry.sv
module critEntry
  import critEntryPkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int STATE_W = 32,
  parameter int OFF_W   = 12,
  parameter int ALIGN_W = 4,
  localparam int PFX_W  = ADDR_W - OFF_W - ALIGN_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqN,
  input  logic               autoVecN,
  input  logic [OFF_W-1:0]   extOff,
  input  logic [ADDR_W-1:0]  nextPc,
  input  logic [STATE_W-1:0] stateIn,
  input  logic [PFX_W-1:0]   vecPrefix,
  input  logic [OFF_W-1:0]   vecOffReg,
  input  logic [1:0]         dbgCfg,
  output logic [ADDR_W-1:0]  retSave,
  output logic [STATE_W-1:0] stateSave,
  output logic [STATE_W-1:0] stateNew,
  output logic [ADDR_W-1:0]  vecOut,
  output logic               takeOut
);

  entryStrobe_t strobe;

  critEntryCtl u_ctl (
    .clk       (clk),
    .rstN      (rstN),
    .reqN      (reqN),
    .autoVecN  (autoVecN),
    .critEn    (stateIn[ST_CRIT_EN]),
    .dbgUnitEn (dbgCfg[0]),
    .dbgClrCfg (dbgCfg[1]),
    .strobe    (strobe),
    .takeOut   (takeOut)
  );

  critEntryDp #(
    .ADDR_W  (ADDR_W),
    .STATE_W (STATE_W),
    .OFF_W   (OFF_W),
    .ALIGN_W (ALIGN_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .extOff    (extOff),
    .nextPc    (nextPc),
    .stateIn   (stateIn),
    .vecPrefix (vecPrefix),
    .vecOffReg (vecOffReg),
    .retSave   (retSave),
    .stateSave (stateSave),
    .stateNew  (stateNew),
    .vecOut    (vecOut)
  );

endmodule

// File: rtl/critEntryChk.sv
module critEntryChk
  import critEntryPkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int STATE_W = 32,
  parameter int OFF_W   = 12,
  parameter int ALIGN_W = 4,
  localparam int PFX_W  = ADDR_W - OFF_W - ALIGN_W
) (
  input logic               clk,
  input logic               rstN,
  input logic               reqN,
  input logic [ADDR_W-1:0]  nextPc,
  input logic [STATE_W-1:0] stateIn,
  input logic [PFX_W-1:0]   vecPrefix,
  input logic [ADDR_W-1:0]  retSave,
  input logic [STATE_W-1:0] stateSave,
  input logic [STATE_W-1:0] stateNew,
  input logic [ADDR_W-1:0]  vecOut,
  input logic               takeOut
);

  p_take_cond_r2: assert property (@(posedge clk) disable iff (!rstN)
    takeOut |-> ($past(!reqN) && $past(stateIn[ST_CRIT_EN])));

  p_vec_form_r3: assert property (@(posedge clk) disable iff (!rstN)
    takeOut |-> (vecOut[ALIGN_W-1:0] == '0 &&
                 vecOut[ADDR_W-1 -: PFX_W] == $past(vecPrefix)));

  p_save_regs_r5: assert property (@(posedge clk) disable iff (!rstN)
    takeOut |-> (retSave == $past(nextPc) && stateSave == $past(stateIn)));

  p_new_state_r6: assert property (@(posedge clk) disable iff (!rstN)
    takeOut |-> (!stateNew[ST_CRIT_EN] &&
                 stateNew[ST_MCHK_EN] == $past(stateIn[ST_MCHK_EN])));

  p_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !takeOut |-> ($stable(vecOut) && $stable(retSave) &&
                  $stable(stateSave) && $stable(stateNew)));

  p_single_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    takeOut |=> !takeOut);

endmodule

bind critEntry critEntryChk #(
  .ADDR_W  (ADDR_W),
  .STATE_W (STATE_W),
  .OFF_W   (OFF_W),
  .ALIGN_W (ALIGN_W)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .reqN      (reqN),
  .nextPc    (nextPc),
  .stateIn   (stateIn),
  .vecPrefix (vecPrefix),
  .retSave   (retSave),
  .stateSave (stateSave),
  .stateNew  (stateNew),
  .vecOut    (vecOut),
  .takeOut   (takeOut)
);

// File: tb/critEntry_test.sv
`timescale 1ns/1ps
module critEntry_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqN = 1'b1;
  logic        autoVecN = 1'b0;
  logic [11:0] extOff = '0;
  logic [31:0] nextPc = '0;
  logic [31:0] stateIn = '0;
  logic [15:0] vecPrefix = '0;
  logic [11:0] vecOffReg = '0;
  logic [1:0]  dbgCfg = '0;
  logic [31:0] retSave, stateSave, stateNew, vecOut;
  logic        takeOut;

  int checks = 0;
  int failures = 0;

  localparam logic [31:0] CLR_BITS = (32'd1 << 26) | (32'd1 << 25) | (32'd1 << 18) |
    (32'd1 << 17) | (32'd1 << 15) | (32'd1 << 14) | (32'd1 << 13) | (32'd1 << 11) |
    (32'd1 << 8) | (32'd1 << 5) | (32'd1 << 4) | (32'd1 << 1);
  localparam logic [31:0] CE_BIT = 32'd1 << 17;

  always #5 clk = ~clk;

  critEntry uut (
    .clk(clk), .rstN(rstN), .reqN(reqN), .autoVecN(autoVecN), .extOff(extOff),
    .nextPc(nextPc), .stateIn(stateIn), .vecPrefix(vecPrefix), .vecOffReg(vecOffReg),
    .dbgCfg(dbgCfg), .retSave(retSave), .stateSave(stateSave), .stateNew(stateNew),
    .vecOut(vecOut), .takeOut(takeOut)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL R2 watchdog actual=running expected=finished");
    summary();
  end

  initial begin
    logic [31:0] pVec, pRet, pSave, pNew, st, expNew;
    logic [11:0] offUsed;

    // R1: reset state
    repeat (2) @(negedge clk);
    chk("R1 take", {31'd0, takeOut}, 0);
    chk("R1 vec", vecOut, 0);
    chk("R1 ret", retSave, 0);
    chk("R1 save", stateSave | stateNew, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 after release", vecOut | retSave | stateSave | stateNew | {31'd0, takeOut}, 0);

    // sweep: enable x request x autovector x debug config x data pattern
    for (int ce = 0; ce < 2; ce++)
      for (int rq = 0; rq < 2; rq++)
        for (int av = 0; av < 2; av++)
          for (int dc = 0; dc < 4; dc++)
            for (int pt = 0; pt < 4; pt++) begin
              case (pt)
                0: st = 32'hFFFF_FFFF;
                1: st = 32'h0000_0000;
                2: st = 32'hA5A5_5A5A;
                default: st = 32'h5A5A_A5A5;
              endcase
              // arming cycle: enable low, no request
              reqN = 1'b1;
              stateIn = st & ~CE_BIT;
              @(negedge clk);
              pVec = vecOut; pRet = retSave; pSave = stateSave; pNew = stateNew;
              stateIn   = ce[0] ? (st | CE_BIT) : (st & ~CE_BIT);
              reqN      = rq[0];
              autoVecN  = av[0];
              dbgCfg    = dc[1:0];
              extOff    = 12'h123 + 12'(pt * 12'h211) + 12'(dc);
              vecOffReg = 12'hE40 ^ 12'(pt * 12'h0C3 + av);
              vecPrefix = 16'h8000 + 16'(pt * 16'h1357) + 16'(ce * 4 + rq);
              nextPc    = 32'h0040_0000 + 32'(pt * 32'h0001_0104) + 32'(dc * 4);
              @(negedge clk);
              if (rq == 0 && ce == 1) begin
                offUsed = av[0] ? extOff : vecOffReg;
                expNew = stateIn & ~CLR_BITS;
                if (!dbgCfg[0] || dbgCfg[1]) expNew[9] = 1'b0;
                chk("R2 take", {31'd0, takeOut}, 1);
                chk("R3 R4 vector", vecOut, {16'h0, vecPrefix} * 32'h10000 + {20'h0, offUsed} * 32'h10);
                chk("R5 ret", retSave, nextPc);
                chk("R5 state save", stateSave, stateIn);
                chk("R6 R7 new state", stateNew, expNew);
                pVec = vecOut; pRet = retSave;
                // hold request and enable: no re-entry, values held
                @(negedge clk);
                chk("R9 single pulse", {31'd0, takeOut}, 0);
                @(negedge clk);
                chk("R9 no retake", {31'd0, takeOut}, 0);
                chk("R8 held vec", vecOut, pVec);
                chk("R8 held ret", retSave, pRet);
              end else begin
                chk("R2 no take", {31'd0, takeOut}, 0);
                chk("R8 unchanged", vecOut ^ pVec ^ retSave ^ pRet ^ stateSave ^ pSave ^ stateNew ^ pNew, 0);
              end
            end

    // R10: pending while enable low, taken when enable rises
    reqN = 1'b1; stateIn = 32'h0; autoVecN = 1'b0;
    @(negedge clk);
    reqN = 1'b0;
    repeat (3) begin
      @(negedge clk);
      chk("R10 pending", {31'd0, takeOut}, 0);
    end
    stateIn = CE_BIT | 32'h0000_1000; nextPc = 32'hCAFE_0010;
    @(negedge clk);
    chk("R10 taken", {31'd0, takeOut}, 1);
    chk("R6 machine check kept", stateNew, 32'h0000_1000);
    chk("R5 ret pending", retSave, 32'hCAFE_0010);

    // R9: request held; rearm needs enable low then high
    repeat (3) begin
      @(negedge clk);
      chk("R9 held quiet", {31'd0, takeOut}, 0);
    end
    stateIn = 32'h0;
    @(negedge clk);
    chk("R9 enable low", {31'd0, takeOut}, 0);
    stateIn = CE_BIT; nextPc = 32'h0000_BEE0;
    @(negedge clk);
    chk("R9 rearmed take", {31'd0, takeOut}, 1);
    chk("R9 rearmed ret", retSave, 32'h0000_BEE0);
    @(negedge clk);
    chk("R9 pulse ends", {31'd0, takeOut}, 0);

    reqN = 1'b1;
    @(negedge clk);
    summary();
  end

endmodule